// File: doc/BRIEF.md
# Host Transaction Request Queue

This block sits between software and a USB host scheduler. Software programs a set of host channels, each with an endpoint class (periodic or nonperiodic), a direction (IN or OUT) and a transaction length in 32-bit words. Requests from the channels are routed into two request queues, one periodic and one nonperiodic. Each queue is paired with its own transmit data FIFO. For an OUT request, software enables the channel and then writes the payload through that channel's push address. The words go into the FIFO chosen by the channel's configured class, whatever address was used to reach it. The queue entry is created only when the final payload word lands in the FIFO. For an IN request, the enable alone creates the entry.

Software watches the free-entry counts of both queues and the free-word counts of both FIFOs. Each FIFO drives an interrupt that fires either at half empty or at fully empty, depending on a mode input. A built-in scheduler serves the periodic queue ahead of the nonperiodic one. It streams each transaction out on a valid/ready port. When the transaction completes, the scheduler retires the entry, clears the channel's enable bit and raises that channel's done flag.

Software must push the payload of each OUT transaction into a FIFO without interleaving another transaction's words on the same FIFO.

Top module: `usbh_txq_top`

## Requirements
- R1: After reset both queues report 8 free entries and both FIFOs report 128 free words. No channel is enabled or done, `tx_valid` is low, both overflow flags are low, and both interrupts are high.
- R2: A channel configuration (op_kind 0) is taken from op_data as follows: bit 0 set means periodic, bit 1 set means IN, and bits 15:8 give the length in words. A word pushed (op_kind 2) to an enabled OUT channel lands in the periodic FIFO when that channel is periodic, otherwise in the nonperiodic FIFO. The other FIFO is untouched.
- R3: An OUT transaction of length N adds one entry to its queue at the moment the N-th word is accepted and not before. Enabling an OUT channel adds no entry.
- R4: Enabling (op_kind 1) an IN channel adds one entry to its class's queue at once and consumes no FIFO space.
- R5: A push to a channel that is disabled, configured IN, or already holding its full length is ignored. A configuration or enable aimed at an enabled channel is also ignored.
- R6: An insert into a full queue, or a push into a full FIFO, is dropped and sets a sticky overflow flag (`q_ovf` or `f_ovf`). An IN enable that loses its entry this way leaves the channel disabled.
- R7: When the scheduler is idle and both queues hold entries, the periodic head is served first.
- R8: An OUT transaction of length N leaves as exactly N beats carrying the FIFO words in push order, with `tx_in` low and `tx_last` on beat N. An IN transaction leaves as a single beat with `tx_in` high, `tx_last` high and data zero. `tx_ch` names the channel in both cases.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_ch`, `tx_in` and `tx_last` hold their values.
- R10: An entry keeps occupying its queue until its last beat is accepted. Its slot is free in the count on the next cycle.
- R11: When the last beat is accepted, the channel's enable bit clears and its done flag sets. A later enable of that channel clears done.
- R12: With `irq_mode` low, a FIFO interrupt is high while the FIFO's free words are at least 64. With `irq_mode` high, it is high only while all 128 words are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Software operation strobe |
| op_kind | input | 2 | 0 configure, 1 enable, 2 push word |
| op_ch | input | 4 | Target channel (push address selector) |
| op_data | input | 32 | Configuration fields or payload word |
| irq_mode | input | 1 | 0 half-empty interrupt, 1 empty interrupt |
| ch_en | output | 16 | Per-channel enable bits |
| ch_done | output | 16 | Per-channel done flags |
| per_q_free | output | 4 | Free entries in periodic queue |
| np_q_free | output | 4 | Free entries in nonperiodic queue |
| per_f_free | output | 8 | Free words in periodic FIFO |
| np_f_free | output | 8 | Free words in nonperiodic FIFO |
| irq_per | output | 1 | Periodic FIFO interrupt |
| irq_np | output | 1 | Nonperiodic FIFO interrupt |
| q_ovf | output | 1 | Sticky queue overflow |
| f_ovf | output | 1 | Sticky FIFO overflow |
| tx_valid | output | 1 | Outgoing beat valid |
| tx_ready | input | 1 | Outgoing beat accepted |
| tx_data | output | 32 | Payload word (zero for IN) |
| tx_ch | output | 4 | Channel of the transaction |
| tx_in | output | 1 | Beat is an IN request |
| tx_last | output | 1 | Final beat of the transaction |

## Verification
The embedded assertions check four things on every cycle. No FIFO or queue is written while full or read while empty. Occupancy never exceeds depth. A stalled beat holds steady. The scheduler never completes a transaction for a channel that is not enabled, and while the scheduler is busy its chosen queue is never empty. Other behaviours only the bench scenarios can show. These include routing by endpoint class, the exact cycle on which an OUT entry appears, and periodic-first ordering across queued work. The rest are the dropped pushes, sticky overflow, done and enable handover, and both interrupt thresholds. All of these are observed through the status counts and the scoreboarded output stream.

// File: rtl/usbh_txq_pkg.sv
// Shared constants for the host transaction request queue.
// Assumes queue index 0 is periodic and 1 is nonperiodic throughout.
package usbh_txq_pkg;
    typedef enum logic [1:0] {
        OP_CFG  = 2'd0,
        OP_EN   = 2'd1,
        OP_PUSH = 2'd2,
        OP_NONE = 2'd3
    } op_kind_e;

    localparam int CFG_PER_BIT = 0;
    localparam int CFG_IN_BIT  = 1;
    localparam int CFG_LEN_LSB = 8;

    localparam int Q_PER = 0;
    localparam int Q_NP  = 1;
endpackage

// File: rtl/usbh_txq_fifo.sv
// Synchronous first-in first-out store with a free-slot count.
// Used both for request queues and payload FIFOs.
// Assumes the caller never writes when full nor reads when empty; D >= 2.
module usbh_txq_fifo #(
    parameter int W = 32,
    parameter int D = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [W-1:0]            wr_data,
    input  logic                    rd_en,
    output logic [W-1:0]            rd_data,
    output logic                    empty,
    output logic                    full,
    output logic [$clog2(D+1)-1:0]  free
);
    localparam int AW = $clog2(D);
    localparam int CW = $clog2(D + 1);

    logic [W-1:0]  mem [D];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          wr_ok, rd_ok;

    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(D));
    assign free    = CW'(D) - cnt;
    assign rd_data = mem[rd_ptr];

    // Storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == AW'(D - 1)) ? '0 : wr_ptr + AW'(1);
            if (rd_ok) rd_ptr <= (rd_ptr == AW'(D - 1)) ? '0 : rd_ptr + AW'(1);
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(D));
endmodule

// File: rtl/usbh_txq_chan.sv
// Host channel register file and request router.
// Holds each channel's class, direction, length, enable, done and pushed-word count.
// It decodes software operations into FIFO writes and queue inserts.
// Assumes one operation per cycle and OUT length >= 1.
module usbh_txq_chan
    import usbh_txq_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int LENW = 8,
    parameter int DW   = 32,
    localparam int CHW = $clog2(NCH),
    localparam int EW  = CHW + 1 + LENW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_kind,
    input  logic [CHW-1:0]  op_ch,
    input  logic [DW-1:0]   op_data,
    input  logic [1:0]      q_full,
    input  logic [1:0]      f_full,
    input  logic            fin_valid,
    input  logic [CHW-1:0]  fin_ch,
    output logic [NCH-1:0]  ch_en,
    output logic [NCH-1:0]  ch_done,
    output logic [1:0]      f_wr,
    output logic [DW-1:0]   f_wdata,
    output logic [1:0]      q_wr,
    output logic [EW-1:0]   q_wdata,
    output logic            q_ovf,
    output logic            f_ovf
);
    logic [NCH-1:0]  per_r, in_r, en_q, done_q;
    logic [LENW-1:0] len_r [NCH];
    logic [LENW-1:0] cnt_r [NCH];
    logic            q_ovf_q, f_ovf_q;

    logic tgt;
    logic is_cfg, is_en, is_push, push_ok, push_drop, push_final;
    logic ins_req, ins_ok, ins_drop, en_set;

    // Decode the current operation against the addressed channel's state.
    always_comb begin
        tgt        = per_r[op_ch] ? 1'(Q_PER) : 1'(Q_NP);
        is_cfg     = op_valid && (op_kind == OP_CFG) && !en_q[op_ch];
        is_en      = op_valid && (op_kind == OP_EN)  && !en_q[op_ch];
        is_push    = op_valid && (op_kind == OP_PUSH) && en_q[op_ch]
                     && !in_r[op_ch] && (cnt_r[op_ch] < len_r[op_ch]);
        push_ok    = is_push && !f_full[tgt];
        push_drop  = is_push &&  f_full[tgt];
        push_final = push_ok && ((cnt_r[op_ch] + LENW'(1)) == len_r[op_ch]);
        ins_req    = (is_en && in_r[op_ch]) || push_final;
        ins_ok     = ins_req && !q_full[tgt];
        ins_drop   = ins_req &&  q_full[tgt];
        en_set     = is_en && !ins_drop;
        f_wr       = '0;
        q_wr       = '0;
        if (push_ok) f_wr[tgt] = 1'b1;
        if (ins_ok)  q_wr[tgt] = 1'b1;
    end

    assign f_wdata = op_data;
    assign q_wdata = {op_ch, in_r[op_ch], len_r[op_ch]};
    assign ch_en   = en_q;
    assign ch_done = done_q;
    assign q_ovf   = q_ovf_q;
    assign f_ovf   = f_ovf_q;

    // Channel configuration capture while the channel is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_r <= '0;
            in_r  <= '0;
            for (int i = 0; i < NCH; i++) len_r[i] <= '0;
        end else if (is_cfg) begin
            per_r[op_ch] <= op_data[CFG_PER_BIT];
            in_r[op_ch]  <= op_data[CFG_IN_BIT];
            len_r[op_ch] <= op_data[CFG_LEN_LSB +: LENW];
        end
    end

    // Pushed-word counters, restarted on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) cnt_r[i] <= '0;
        end else if (is_en) begin
            cnt_r[op_ch] <= '0;
        end else if (push_ok) begin
            cnt_r[op_ch] <= cnt_r[op_ch] + LENW'(1);
        end
    end

    // Enable and done flags: set by software enable, handed over at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            done_q <= '0;
        end else begin
            if (is_en) done_q[op_ch] <= 1'b0;
            if (en_set) en_q[op_ch] <= 1'b1;
            if (fin_valid) begin
                en_q[fin_ch]   <= 1'b0;
                done_q[fin_ch] <= 1'b1;
            end
        end
    end

    // Sticky overflow flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_ovf_q <= 1'b0;
            f_ovf_q <= 1'b0;
        end else begin
            if (ins_drop)  q_ovf_q <= 1'b1;
            if (push_drop) f_ovf_q <= 1'b1;
        end
    end

    assert_finish_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fin_valid |-> en_q[fin_ch]);
endmodule

// File: rtl/usbh_txq_sched.sv
// Transaction scheduler: locks onto one queue head and streams it out.
// The periodic queue takes priority when idle. The entry stays in its queue
// until its last beat is accepted. Assumes OUT payload words sit in FIFO order.
module usbh_txq_sched #(
    parameter int CHW  = 4,
    parameter int LENW = 8,
    parameter int DW   = 32,
    localparam int EW  = CHW + 1 + LENW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          q_empty,
    input  logic [1:0][EW-1:0]  q_head,
    input  logic [1:0]          f_empty,
    input  logic [1:0][DW-1:0]  f_head,
    input  logic                tx_ready,
    output logic [1:0]          q_pop,
    output logic [1:0]          f_pop,
    output logic                tx_valid,
    output logic [DW-1:0]       tx_data,
    output logic [CHW-1:0]      tx_ch,
    output logic                tx_in,
    output logic                tx_last,
    output logic                fin_valid,
    output logic [CHW-1:0]      fin_ch
);
    logic            busy, sel;
    logic [LENW-1:0] idx;
    logic [EW-1:0]   head;
    logic [CHW-1:0]  h_ch;
    logic            h_in;
    logic [LENW-1:0] h_len;
    logic            hs;

    // Unpack the locked head entry and form the outgoing beat.
    always_comb begin
        head     = q_head[sel];
        h_ch     = head[EW-1 -: CHW];
        h_in     = head[LENW];
        h_len    = head[LENW-1:0];
        tx_valid = busy && (h_in || !f_empty[sel]);
        tx_last  = h_in || (idx == (h_len - LENW'(1)));
        tx_data  = h_in ? '0 : f_head[sel];
        tx_ch    = h_ch;
        tx_in    = h_in;
        hs       = tx_valid && tx_ready;
        q_pop    = '0;
        f_pop    = '0;
        if (hs && !h_in)   f_pop[sel] = 1'b1;
        if (hs && tx_last) q_pop[sel] = 1'b1;
    end

    assign fin_valid = hs && tx_last;
    assign fin_ch    = h_ch;

    // Queue selection when idle, beat counting while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sel  <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            idx <= '0;
            if (!q_empty[0]) begin
                busy <= 1'b1;
                sel  <= 1'b0;
            end else if (!q_empty[1]) begin
                busy <= 1'b1;
                sel  <= 1'b1;
            end
        end else if (hs) begin
            if (tx_last) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + LENW'(1);
            end
        end
    end

    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_ch)
                                      && $stable(tx_in) && $stable(tx_last)));
    assert_head_present_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !q_empty[sel]);
endmodule

// File: rtl/usbh_txq_top.sv
// Host transaction request queue top level.
// Builds two request queues and two payload FIFOs (periodic, nonperiodic) by
// generate, wires the channel router and the scheduler, and forms status and
// FIFO interrupts. Assumes FDEPTH is even.
module usbh_txq_top #(
    parameter int NCH    = 16,
    parameter int QDEPTH = 8,
    parameter int FDEPTH = 128,
    parameter int LENW   = 8,
    parameter int DW     = 32,
    localparam int CHW   = $clog2(NCH),
    localparam int QCW   = $clog2(QDEPTH + 1),
    localparam int FCW   = $clog2(FDEPTH + 1),
    localparam int EW    = CHW + 1 + LENW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_kind,
    input  logic [CHW-1:0]  op_ch,
    input  logic [DW-1:0]   op_data,
    input  logic            irq_mode,
    output logic [NCH-1:0]  ch_en,
    output logic [NCH-1:0]  ch_done,
    output logic [QCW-1:0]  per_q_free,
    output logic [QCW-1:0]  np_q_free,
    output logic [FCW-1:0]  per_f_free,
    output logic [FCW-1:0]  np_f_free,
    output logic            irq_per,
    output logic            irq_np,
    output logic            q_ovf,
    output logic            f_ovf,
    output logic            tx_valid,
    input  logic            tx_ready,
    output logic [DW-1:0]   tx_data,
    output logic [CHW-1:0]  tx_ch,
    output logic            tx_in,
    output logic            tx_last
);
    logic [1:0]          q_wr, q_pop, q_full, q_empty;
    logic [1:0]          f_wr, f_pop, f_full, f_empty;
    logic [EW-1:0]       q_wdata;
    logic [DW-1:0]       f_wdata;
    logic [1:0][EW-1:0]  q_head;
    logic [1:0][DW-1:0]  f_head;
    logic [QCW-1:0]      q_free [2];
    logic [FCW-1:0]      f_free [2];
    logic [1:0]          irq_v;
    logic                fin_valid;
    logic [CHW-1:0]      fin_ch;

    usbh_txq_chan #(.NCH(NCH), .LENW(LENW), .DW(DW)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_kind(op_kind), .op_ch(op_ch), .op_data(op_data),
        .q_full(q_full), .f_full(f_full),
        .fin_valid(fin_valid), .fin_ch(fin_ch),
        .ch_en(ch_en), .ch_done(ch_done),
        .f_wr(f_wr), .f_wdata(f_wdata), .q_wr(q_wr), .q_wdata(q_wdata),
        .q_ovf(q_ovf), .f_ovf(f_ovf)
    );

    // One queue, one FIFO and one interrupt per traffic class.
    for (genvar g = 0; g < 2; g++) begin : g_class
        usbh_txq_fifo #(.W(EW), .D(QDEPTH)) u_q (
            .clk(clk), .rst_n(rst_n),
            .wr_en(q_wr[g]), .wr_data(q_wdata),
            .rd_en(q_pop[g]), .rd_data(q_head[g]),
            .empty(q_empty[g]), .full(q_full[g]), .free(q_free[g])
        );
        usbh_txq_fifo #(.W(DW), .D(FDEPTH)) u_f (
            .clk(clk), .rst_n(rst_n),
            .wr_en(f_wr[g]), .wr_data(f_wdata),
            .rd_en(f_pop[g]), .rd_data(f_head[g]),
            .empty(f_empty[g]), .full(f_full[g]), .free(f_free[g])
        );
        assign irq_v[g] = irq_mode ? (f_free[g] == FCW'(FDEPTH))
                                   : (f_free[g] >= FCW'(FDEPTH / 2));
    end

    usbh_txq_sched #(.CHW(CHW), .LENW(LENW), .DW(DW)) u_sched (
        .clk(clk), .rst_n(rst_n),
        .q_empty(q_empty), .q_head(q_head),
        .f_empty(f_empty), .f_head(f_head),
        .tx_ready(tx_ready),
        .q_pop(q_pop), .f_pop(f_pop),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ch(tx_ch),
        .tx_in(tx_in), .tx_last(tx_last),
        .fin_valid(fin_valid), .fin_ch(fin_ch)
    );

    assign per_q_free = q_free[0];
    assign np_q_free  = q_free[1];
    assign per_f_free = f_free[0];
    assign np_f_free  = f_free[1];
    assign irq_per    = irq_v[0];
    assign irq_np     = irq_v[1];
endmodule

// File: tb/sim_usbh_txq_top.sv
`timescale 1ns/1ps
module sim_usbh_txq_top;
    import usbh_txq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd3;
    logic [3:0]  op_ch = '0;
    logic [31:0] op_data = '0;
    logic        irq_mode = 1'b0;
    logic [15:0] ch_en, ch_done;
    logic [3:0]  per_q_free, np_q_free;
    logic [7:0]  per_f_free, np_f_free;
    logic        irq_per, irq_np, q_ovf, f_ovf;
    logic        tx_valid, tx_in, tx_last;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic [3:0]  tx_ch;

    typedef struct packed {
        logic [3:0]  ch;
        logic        in_;
        logic [31:0] data;
        logic        last;
    } beat_t;

    beat_t sb[$];
    beat_t mon_e;
    int n_checks = 0;
    int n_fail = 0;
    int rdy_mode = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    usbh_txq_top u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_ch(op_ch), .op_data(op_data), .irq_mode(irq_mode),
        .ch_en(ch_en), .ch_done(ch_done),
        .per_q_free(per_q_free), .np_q_free(np_q_free),
        .per_f_free(per_f_free), .np_f_free(np_f_free),
        .irq_per(irq_per), .irq_np(irq_np), .q_ovf(q_ovf), .f_ovf(f_ovf),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_ch(tx_ch), .tx_in(tx_in), .tx_last(tx_last)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Drive one operation for one cycle; called at a falling edge.
    task automatic op(input logic [1:0] k, input int ch, input logic [31:0] d);
        op_valid = 1'b1;
        op_kind  = k;
        op_ch    = 4'(ch);
        op_data  = d;
        @(negedge clk);
        op_valid = 1'b0;
        op_kind  = 2'd3;
    endtask

    task automatic expect_beat(input int ch, input bit in_, input logic [31:0] d, input bit last);
        sb.push_back('{ch: 4'(ch), in_: in_, data: d, last: last});
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Ready pattern: 0 stalled, 1 always ready, otherwise alternating.
    always @(posedge clk) begin
        case (rdy_mode)
            0:       tx_ready <= 1'b0;
            1:       tx_ready <= 1'b1;
            default: tx_ready <= ~tx_ready;
        endcase
    end

    // Monitor: compare every accepted beat with the scoreboard head (R7, R8).
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (sb.size() == 0) begin
                check("R8 unexpected beat", {tx_ch, tx_in, tx_data, tx_last}, 64'h0);
            end else begin
                mon_e = sb.pop_front();
                check("R7/R8 beat", {26'h0, tx_ch, tx_in, tx_data, tx_last}, {26'h0, mon_e});
            end
        end
    end

    // Watchdog counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d pending beats expected 0", sb.size());
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 queue free", {per_q_free, np_q_free}, {4'd8, 4'd8});
        check("R1 fifo free", {per_f_free, np_f_free}, {8'd128, 8'd128});
        check("R1 flags", {ch_en, ch_done, tx_valid, q_ovf, f_ovf, irq_per, irq_np},
              {16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});

        // Phase A: routing, entry timing, ignored ops, hold, priority.
        op(OP_CFG, 0, 32'h0000_0300);   // OUT nonperiodic, 3 words
        op(OP_CFG, 1, 32'h0000_0103);   // IN periodic
        op(OP_CFG, 2, 32'h0000_0100);   // OUT nonperiodic, 1 word
        op(OP_EN, 0, 32'h0);
        check("R3 OUT enable adds no entry", np_q_free, 4'd8);
        op(OP_PUSH, 0, 32'hA000_0000);
        op(OP_PUSH, 0, 32'hA000_0001);
        check("R2 words in nonperiodic fifo", np_f_free, 8'd126);
        check("R2 periodic fifo untouched", per_f_free, 8'd128);
        check("R3 no entry before final word", np_q_free, 4'd8);
        op(OP_PUSH, 0, 32'hA000_0002);
        check("R3 entry on final word", np_q_free, 4'd7);
        op(OP_PUSH, 0, 32'hDEAD_0000);
        check("R5 push beyond length ignored", np_f_free, 8'd125);
        op(OP_PUSH, 2, 32'hDEAD_0001);
        check("R5 push to disabled channel ignored", np_f_free, 8'd125);
        op(OP_CFG, 0, 32'h0000_0103);   // ignored: channel 0 enabled (R5)
        check("R9 stalled beat", {tx_valid, tx_ch, tx_data}, {1'b1, 4'd0, 32'hA000_0000});
        repeat (3) @(negedge clk);
        check("R9 beat held", {tx_valid, tx_ch, tx_data, tx_last},
              {1'b1, 4'd0, 32'hA000_0000, 1'b0});
        op(OP_EN, 2, 32'h0);
        op(OP_PUSH, 2, 32'hC2C2_0001);
        check("R10 active entry still counted", np_q_free, 4'd6);
        op(OP_EN, 1, 32'h0);
        check("R4 IN enable adds entry", per_q_free, 4'd7);
        check("R4 IN uses no fifo", per_f_free, 8'd128);
        expect_beat(0, 1'b0, 32'hA000_0000, 1'b0);  // R8 (R5: cfg ignored, stays OUT)
        expect_beat(0, 1'b0, 32'hA000_0001, 1'b0);
        expect_beat(0, 1'b0, 32'hA000_0002, 1'b1);
        expect_beat(1, 1'b1, 32'h0, 1'b1);          // R7: periodic before queued ch2
        expect_beat(2, 1'b0, 32'hC2C2_0001, 1'b1);
        rdy_mode = 2;
        drain();
        check("R10 slots freed", {per_q_free, np_q_free}, {4'd8, 4'd8});
        check("R8 fifos drained", {per_f_free, np_f_free}, {8'd128, 8'd128});
        check("R11 enable cleared", ch_en[2:0], 3'b000);
        check("R11 done set", ch_done[2:0], 3'b111);
        op(OP_EN, 0, 32'h0);
        check("R11 re-enable clears done", {ch_en[0], ch_done[0]}, 2'b10);

        // Phase B: queue overflow.
        rdy_mode = 0;
        repeat (2) @(negedge clk);
        for (int c = 4; c <= 12; c++) op(OP_CFG, c, 32'h0000_0102);
        for (int c = 4; c <= 12; c++) op(OP_EN, c, 32'h0);
        check("R6 queue full", np_q_free, 4'd0);
        check("R6 queue overflow flags", {q_ovf, f_ovf}, 2'b10);
        check("R6 dropped IN stays disabled", {ch_en[12], ch_en[11]}, 2'b01);
        for (int c = 4; c <= 11; c++) expect_beat(c, 1'b1, 32'h0, 1'b1);
        rdy_mode = 1;
        drain();
        check("R6 queue flag sticky", q_ovf, 1'b1);
        check("R11 all done", ch_done[11:4], 8'hFF);
        check("R10 queue empty again", np_q_free, 4'd8);

        // Phase C: FIFO thresholds and FIFO overflow.
        op(OP_CFG, 13, 32'h0000_C801);  // OUT periodic, 200 words
        op(OP_EN, 13, 32'h0);
        for (int i = 0; i < 64; i++) op(OP_PUSH, 13, 32'(i));
        check("R2 periodic fifo filling", {per_f_free, np_f_free}, {8'd64, 8'd128});
        check("R12 half-empty at 64 free", irq_per, 1'b1);
        op(OP_PUSH, 13, 32'h40);
        check("R12 below half", {per_f_free, irq_per}, {8'd63, 1'b0});
        irq_mode = 1'b1;
        #1;
        check("R12 empty mode", {irq_per, irq_np}, 2'b01);
        irq_mode = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 63; i++) op(OP_PUSH, 13, 32'(i + 65));
        check("R6 fifo full, no drop yet", {per_f_free, f_ovf}, {8'd0, 1'b0});
        op(OP_PUSH, 13, 32'hFFFF_FFFF);
        check("R6 fifo overflow sticky", {per_f_free, f_ovf}, {8'd0, 1'b1});
        check("R3 no entry while short of length", {per_q_free, tx_valid}, {4'd8, 1'b0});

        finish_run();
    end
endmodule